// File: doc/BRIEF.md
# Per-Hart Software Interrupt Bank

This block holds one pending bit per hart and uses it to raise inter-processor software interrupts. Each bit drives a level interrupt line straight to its hart. Software sets or clears a bit by writing the hart's 32-bit word through a small register bus. A side port can rewrite a whole group of harts in one cycle from a base index and a bit mask. A per-hart acknowledge input clears the bit when the hart takes the interrupt.

A parameter picks the flavour. In the machine flavour the stored bits read back. In the supervisor flavour the bank is write-only and every read returns zero. Bus accesses beyond the register window are reported on an error output, so the requester can raise a load or store fault.

Top module: `swi_bank`

## Requirements
- R1: A bus write at byte offset 4*h with h < NHART stores bit 0 of the write data as hart h's pending bit, and discards bits 31..1. swi_irq[h] shows the new value from the cycle after the write.
- R2: Any access at an offset of 0x4000 or more raises bus_err in the following cycle and changes no pending bit. Accesses below 0x4000 leave bus_err low.
- R3: In the machine flavour (SUPERVISOR=0), a read of offset 4*h returns, in the next cycle, the pending bit as it stood when the request was presented, in bit 0, with bits 31..1 zero. A read at an offset whose low two bits are nonzero returns zero, and a write there is ignored.
- R4: In the supervisor flavour (SUPERVISOR=1), bus_rdata is zero after every access, whatever the stored bits.
- R5: Word slots for harts h >= NHART inside the window read as zero and ignore writes, without raising an error.
- R6: With mask_valid high, mask bit k writes its value into the pending bit of hart mask_base+k, for every k up to the highest set bit of mask_bits. Harts below mask_base, harts above that highest bit, and indices without a hart are unchanged. An all-zero mask changes nothing.
- R7: With mask_valid high and mask_base equal to 0xFFFFFFFF, every present hart's pending bit is set to 1, whatever mask_bits holds.
- R8: ack[h] high clears hart h's pending bit at the next edge.
- R9: When a bus write, the mask port and an acknowledge reach the same hart in one cycle, the bus write decides the bit. Without a bus write, the mask port decides it, and the acknowledge decides it only when neither of the others touches that hart.
- R10: After reset all pending bits, swi_irq, bus_rdata and bus_err are zero.
- R11: swi_irq holds its value in every cycle with no bus access, no mask operation and no acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access request for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 32 | Byte offset inside the bank |
| bus_wdata | input | 32 | Write data |
| bus_size | input | 2 | Access size: 0 byte, 1 half, 2 or 3 word |
| bus_rdata | output | 32 | Read data, valid in the cycle after the request |
| bus_err | output | 1 | Out-of-window access, in the cycle after the request |
| mask_valid | input | 1 | Group update strobe |
| mask_base | input | 32 | First hart index of the group; all ones means broadcast |
| mask_bits | input | MASK_W | Values for harts base, base+1, ... |
| ack | input | NHART | Per-hart acknowledge, clears the pending bit |
| swi_irq | output | NHART | Level software-interrupt line per hart |

## Verification
Every input that acts on the bank is registered once. A write, a mask operation or an acknowledge shows on swi_irq in the cycle after the edge that samples it, and read data and the error flag of a request are due in that same following cycle. The bench drives a new stimulus just after each rising edge and keeps a behavioural model that it advances once per edge from the inputs held during the cycle before. It then compares both flavours against the model at that moment. Every output is therefore checked on every clock, exactly one register stage after its cause.

// File: rtl/swi_bank.sv
module swi_bank #(
  parameter int NHART      = 4,
  parameter int SLOTS      = 4096,
  parameter int MASK_W     = 32,
  parameter int SUPERVISOR = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [31:0]       bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic [1:0]        bus_size,
  output logic [31:0]       bus_rdata,
  output logic              bus_err,
  input  logic              mask_valid,
  input  logic [31:0]       mask_base,
  input  logic [MASK_W-1:0] mask_bits,
  input  logic [NHART-1:0]  ack,
  output logic [NHART-1:0]  swi_irq
);
  localparam int WIN   = SLOTS * 4;
  localparam int IDX_W = $clog2(SLOTS);

  logic [NHART-1:0] pend, pend_nxt;
  logic [IDX_W-1:0] slot;
  logic             in_win, lane0, wr_hit, bcast;
  logic [NHART-1:0] rd_sh;
  logic [31:0]      size_mask, rd_word;

  assign in_win = bus_addr < 32'(WIN);
  assign slot   = bus_addr[IDX_W+1:2];
  assign lane0  = bus_addr[1:0] == 2'b00;
  assign wr_hit = bus_sel & bus_we & in_win & lane0;
  assign bcast  = mask_valid & (mask_base == 32'hFFFF_FFFF);

  for (genvar h = 0; h < NHART; h++) begin : g_hart
    logic [31:0]       off;
    logic [MASK_W-1:0] shifted;
    logic              ge, m_hit, m_val, b_hit;
    always_comb begin
      ge      = 32'(h) >= mask_base;
      off     = 32'(h) - mask_base;
      shifted = mask_bits >> off;
      m_hit   = mask_valid & (bcast | (ge & (shifted != '0)));
      m_val   = bcast | shifted[0];
      b_hit   = wr_hit & (32'(slot) == 32'(h));
      pend_nxt[h] = pend[h];
      if (ack[h]) pend_nxt[h] = 1'b0;
      if (m_hit)  pend_nxt[h] = m_val;
      if (b_hit)  pend_nxt[h] = bus_wdata[0];
    end
  end

  assign rd_sh = pend >> slot;

  always_comb begin
    case (bus_size)
      2'd0:    size_mask = 32'h0000_00FF;
      2'd1:    size_mask = 32'h0000_FFFF;
      default: size_mask = 32'hFFFF_FFFF;
    endcase
    rd_word = {31'b0, (SUPERVISOR == 0) & lane0 & rd_sh[0]} & size_mask;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend      <= '0;
      bus_rdata <= '0;
      bus_err   <= 1'b0;
    end else begin
      pend      <= pend_nxt;
      bus_err   <= bus_sel & ~in_win;
      bus_rdata <= (bus_sel & ~bus_we & in_win) ? rd_word : 32'h0;
    end
  end

  assign swi_irq = pend;
endmodule

// File: rtl/swi_bank_chk.sv
module swi_bank_chk #(
  parameter int NHART      = 4,
  parameter int SLOTS      = 4096,
  parameter int MASK_W     = 32,
  parameter int SUPERVISOR = 0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_we,
  input logic [31:0]       bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic              bus_err,
  input logic              mask_valid,
  input logic [31:0]       mask_base,
  input logic [MASK_W-1:0] mask_bits,
  input logic [NHART-1:0]  ack,
  input logic [NHART-1:0]  swi_irq
);
  localparam int WIN = SLOTS * 4;

  a_r2_err_out: assert property (@(posedge clk) disable iff (!rst_n)
    bus_sel && bus_addr >= 32'(WIN) |=> bus_err);
  a_r2_err_in: assert property (@(posedge clk) disable iff (!rst_n)
    bus_sel && bus_addr < 32'(WIN) |=> !bus_err);
  a_r3_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[31:1] == 31'h0);
  a_r4_sup_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (SUPERVISOR != 0) |-> bus_rdata == 32'h0);
  a_r7_bcast: assert property (@(posedge clk) disable iff (!rst_n)
    mask_valid && mask_base == 32'hFFFF_FFFF && !bus_sel && ack == '0 |=> swi_irq == '1);
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_sel && !mask_valid && ack == '0 |=> $stable(swi_irq));

  for (genvar h = 0; h < NHART; h++) begin : g_h
    a_r1_write: assert property (@(posedge clk) disable iff (!rst_n)
      bus_sel && bus_we && bus_addr == 32'(4*h) |=> swi_irq[h] == $past(bus_wdata[0]));
    a_r8_ack: assert property (@(posedge clk) disable iff (!rst_n)
      ack[h] && !mask_valid && !(bus_sel && bus_we && bus_addr == 32'(4*h)) |=> !swi_irq[h]);
  end
endmodule

bind swi_bank swi_bank_chk #(.NHART(NHART), .SLOTS(SLOTS), .MASK_W(MASK_W), .SUPERVISOR(SUPERVISOR)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_err(bus_err), .mask_valid(mask_valid),
  .mask_base(mask_base), .mask_bits(mask_bits), .ack(ack), .swi_irq(swi_irq)
);

// File: tb/swi_bank_tb_top.sv
`timescale 1ns/1ps
module swi_bank_tb_top;
  localparam int NH = 4;
  localparam int MW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel = 1'b0, we = 1'b0, mv = 1'b0;
  logic [31:0] addr = '0, wdata = '0, base = '0;
  logic [1:0]  size = 2'd2;
  logic [MW-1:0] mbits = '0;
  logic [NH-1:0] ack = '0;
  logic [31:0] rd_m, rd_s;
  logic err_m, err_s;
  logic [NH-1:0] irq_m, irq_s;

  int vectors = 0, errors = 0;
  bit done = 0;
  string cur_req = "R10";
  int pend[NH];
  logic [31:0] exp_rd;
  bit exp_err;

  always #2.5 clk = ~clk;

  swi_bank #(.NHART(NH), .MASK_W(MW), .SUPERVISOR(0)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_we(we), .bus_addr(addr),
    .bus_wdata(wdata), .bus_size(size), .bus_rdata(rd_m), .bus_err(err_m),
    .mask_valid(mv), .mask_base(base), .mask_bits(mbits), .ack(ack), .swi_irq(irq_m));

  swi_bank #(.NHART(NH), .MASK_W(MW), .SUPERVISOR(1)) dut_s (
    .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_we(we), .bus_addr(addr),
    .bus_wdata(wdata), .bus_size(size), .bus_rdata(rd_s), .bus_err(err_s),
    .mask_valid(mv), .mask_base(base), .mask_bits(mbits), .ack(ack), .swi_irq(irq_s));

  task automatic model_step();
    int nx[NH];
    exp_rd = 32'h0;
    exp_err = 0;
    if (!rst_n) begin
      foreach (pend[h]) pend[h] = 0;
      return;
    end
    if (sel) begin
      if (addr >= 32'h4000) exp_err = 1;
      else if (!we && addr % 4 == 0 && addr / 4 < NH) exp_rd = 32'(pend[addr / 4]);
    end
    for (int h = 0; h < NH; h++) begin
      longint k;
      nx[h] = pend[h];
      if (ack[h]) nx[h] = 0;
      if (mv) begin
        if (base == 32'hFFFF_FFFF) nx[h] = 1;
        else if (longint'(h) >= longint'(base)) begin
          k = longint'(h) - longint'(base);
          if (k < MW && (mbits >> k) != 0) nx[h] = int'((mbits >> k) & 1);
        end
      end
      if (sel && we && addr == 32'(4 * h)) nx[h] = int'(wdata[0]);
    end
    foreach (pend[h]) pend[h] = nx[h];
  endtask

  task automatic check(string what, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  task automatic tick();
    logic [NH-1:0] ei;
    @(posedge clk);
    #1;
    model_step();
    for (int h = 0; h < NH; h++) ei[h] = pend[h][0];
    check("irq machine", 32'(irq_m), 32'(ei));
    check("irq supervisor", 32'(irq_s), 32'(ei));
    check("rdata machine", rd_m, exp_rd);
    check("rdata supervisor (R4)", rd_s, 32'h0);
    check("err machine", 32'(err_m), 32'(exp_err));
    check("err supervisor", 32'(err_s), 32'(exp_err));
  endtask

  task automatic idle();
    sel = 0; we = 0; mv = 0; ack = '0;
    tick();
  endtask

  task automatic bus_wr(logic [31:0] a, logic [31:0] d);
    sel = 1; we = 1; addr = a; wdata = d;
    tick();
    idle();
  endtask

  task automatic bus_rd(logic [31:0] a, logic [1:0] sz);
    sel = 1; we = 0; addr = a; size = sz;
    tick();
    idle();
    size = 2'd2;
  endtask

  task automatic mask_op(logic [31:0] b, logic [MW-1:0] m);
    mv = 1; base = b; mbits = m;
    tick();
    idle();
  endtask

  task automatic read_all();
    for (int h = 0; h < NH; h++) bus_rd(32'(4 * h), 2'd2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    cur_req = "R10";
    repeat (3) tick();
    rst_n = 1;
    idle(); idle();

    cur_req = "R1";
    bus_wr(32'h0, 32'hFFFF_FFFE);
    bus_wr(32'h4, 32'h0000_0001);
    bus_wr(32'hC, 32'h0000_0003);

    cur_req = "R3";
    read_all();
    bus_rd(32'h5, 2'd0);
    bus_rd(32'h4, 2'd0);
    bus_wr(32'h1, 32'h1);
    bus_wr(32'h6, 32'hFFFF_FFFF);
    read_all();

    cur_req = "R2";
    bus_rd(32'h4000, 2'd2);
    bus_wr(32'h4000, 32'h1);
    bus_wr(32'h4008, 32'h1);
    bus_rd(32'h3FFC, 2'd2);
    bus_rd(32'h8000_0004, 2'd2);

    cur_req = "R5";
    bus_wr(32'h10, 32'h1);
    bus_rd(32'h10, 2'd2);
    bus_rd(32'h3FF8, 2'd2);

    cur_req = "R8";
    ack = 4'b0010;
    tick();
    ack = 4'b1000;
    tick();
    idle();
    read_all();

    cur_req = "R6";
    mask_op(32'd1, 32'b101);
    read_all();
    mask_op(32'd0, 32'b0010);
    mask_op(32'd2, 32'h0);
    mask_op(32'd3, 32'b11);
    mask_op(32'd0, 32'b0);
    mask_op(32'd1, 32'h8000_0000);
    mask_op(32'd9, 32'hFFFF_FFFF);
    read_all();

    cur_req = "R7";
    for (int h = 0; h < NH; h++) bus_wr(32'(4 * h), 32'h0);
    mask_op(32'hFFFF_FFFF, 32'h0);
    read_all();

    cur_req = "R9";
    sel = 1; we = 1; addr = 32'h8; wdata = 32'h0;
    mv = 1; base = 32'hFFFF_FFFF; mbits = '0; ack = 4'b0100;
    tick();
    idle();
    mv = 1; base = 32'd0; mbits = 32'b1; ack = 4'b0011;
    tick();
    idle();
    sel = 1; we = 1; addr = 32'h0; wdata = 32'h0;
    mv = 1; base = 32'd0; mbits = 32'b11;
    tick();
    idle();
    read_all();

    cur_req = "R11";
    repeat (6) idle();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule